// File: doc/BRIEF.md
# VME Release-on-Acknowledge Interrupter

This block turns the interrupt output of an attached peripheral into a VME interrupt request. A 7-bit one-hot configuration vector chooses which of the request levels IRQ1 to IRQ7 the board uses. A rising edge on the peripheral interrupt makes a request pending. While the request is pending, the block pulls the selected request line.

The block watches interrupt-acknowledge cycles on the bus. It answers a cycle when the cycle is for its own level and the daisy chain grants it. It then drives a 16-bit status/ID word on the data lines and asserts DTACK. It drops its request at that point, which is release-on-acknowledge behaviour. When the cycle belongs to another level, or nothing is pending, the block passes the daisy-chain grant on through its chain output. The bus-side inputs are asynchronous to the local clock and are synchronised inside the block.

Top module: `vme_roak_irq`

## Requirements
- R1: Out of reset, no request line is pulled (`irq_pull` = 0), `dtack_n` = 1, `iackout_n` = 1 and `data_oe` = 0.
- R2: A rising edge on `periph_int`, with `level_sel` holding exactly one set bit, pulls exactly the request line that bit selects. Bit n of `level_sel[7:1]` and bit n of `irq_pull[7:1]` both stand for IRQn.
- R3: While `level_sel` is zero or has more than one bit set, a rising edge on `periph_int` pulls no request line.
- R4: An acknowledge cycle is for this block when all of the following hold: `iack_n`, `iackin_n` and `as_n` are low, at least one bit of `ds_n` is low, `addr[3:1]` equals the configured level number (1 to 7), and a request is pending. The block then drives `status_id` on `data_out` with `data_oe` = 1, and after that asserts `dtack_n` low.
- R5: The request line is released by the acknowledge cycle that services it. `irq_pull` is 0 by the time `dtack_n` is low.
- R6: `dtack_n` and `data_oe` stay asserted while either data strobe is low. Both are released within a few clocks after both strobes go high.
- R7: When `addr[3:1]` differs from the configured level, the block drives `iackout_n` low, never asserts `dtack_n`, and keeps its request pulled.
- R8: When no request is pending, an acknowledge cycle at the block's own level is passed on through `iackout_n`, and `dtack_n` stays high.
- R9: After a release, a `periph_int` that stays high raises no new request. Only a fresh low-to-high edge raises one.
- R10: `iackout_n` returns high within a few clocks after `iackin_n` or `as_n` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_int | input | 1 | Interrupt output of the attached peripheral, active high |
| level_sel | input | 7 | One-hot level selection, bit n selects IRQn |
| status_id | input | 16 | Word returned during the acknowledge |
| iack_n | input | 1 | Bus acknowledge-cycle indicator, active low |
| iackin_n | input | 1 | Daisy-chain grant in, active low |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 2 | Data strobes, active low |
| addr | input | 3 | Address bits 3:1, the acknowledged level |
| irq_pull | output | 7 | Request line pull enables, bit n pulls IRQn |
| iackout_n | output | 1 | Daisy-chain grant out, active low |
| dtack_n | output | 1 | Data acknowledge, active low |
| data_oe | output | 1 | Data line output enable |
| data_out | output | 16 | Status/ID word |

## Verification
A pending flag that is stuck or wrongly cleared shows up on `irq_pull` within a handful of clocks of the peripheral edge. A stuck flag also makes an own-level acknowledge pass down the chain instead of being answered. A wrong state in the acknowledge sequencer shows in the same bus cycle. Depending on the fault, `dtack_n` and `iackout_n` both assert, the returned word differs from the queued status/ID, or `dtack_n` drops before the strobes are released. The scoreboard compares every DTACK edge against the word expected for that cycle. It therefore also catches a DTACK that appears when none was expected.

// File: rtl/vme_irq_pkg.sv
package vme_irq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRIVE = 2'd1,
        ST_ACK   = 2'd2,
        ST_PASS  = 2'd3
    } ack_st_e;

    // true when exactly one level bit is set
    function automatic logic sel_is_onehot(input logic [7:1] v);
        int unsigned n;
        n = 0;
        for (int i = 1; i <= 7; i++) n += int'(v[i]);
        return (n == 1);
    endfunction

    // level number 1..7 of the highest set bit, 0 when none
    function automatic logic [2:0] sel_level(input logic [7:1] v);
        logic [2:0] l;
        l = 3'd0;
        for (int i = 1; i <= 7; i++) if (v[i]) l = 3'(i);
        return l;
    endfunction

endpackage

// File: rtl/vme_sync.sv
module vme_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg_q [STAGES];
    logic [WIDTH-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/vme_irq_req.sv
module vme_irq_req
    import vme_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       int_s,
    input  logic [7:1] level_sel,
    input  logic       take,
    output logic       pending,
    output logic [7:1] irq_pull
);
    typedef struct packed {
        logic prev;
        logic pend;
    } req_t;

    req_t r_q, r_d;
    logic cfg_ok;

    assign cfg_ok = sel_is_onehot(level_sel);

    always_comb begin
        r_d      = r_q;
        r_d.prev = int_s;
        if (take)
            r_d.pend = 1'b0;
        else if (int_s && !r_q.prev && cfg_ok)
            r_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pending  = r_q.pend;
    assign irq_pull = (r_q.pend && cfg_ok) ? level_sel : 7'd0;

    // R2
    one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_pull));

    // R9
    no_reraise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.pend && int_s && r_q.prev && !take) |=> !r_q.pend);
endmodule

// File: rtl/vme_iack_fsm.sv
module vme_iack_fsm
    import vme_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        iack_s,
    input  logic        iackin_s,
    input  logic        as_s,
    input  logic [1:0]  ds_s,
    input  logic [3:1]  addr,
    input  logic        pending,
    input  logic [7:1]  level_sel,
    input  logic [15:0] status_id,
    output logic        take,
    output logic        dtack_n,
    output logic        iackout_n,
    output logic        data_oe,
    output logic [15:0] data_out
);
    typedef struct packed {
        ack_st_e     st;
        logic [15:0] word;
    } fsm_t;

    fsm_t f_q, f_d;
    logic cycle_on, mine;

    assign cycle_on = !iack_s && !iackin_s && !as_s && (ds_s != 2'b11);
    assign mine     = pending && sel_is_onehot(level_sel)
                      && (addr == sel_level(level_sel));

    always_comb begin
        f_d  = f_q;
        take = 1'b0;
        unique case (f_q.st)
            ST_IDLE: begin
                if (cycle_on) begin
                    if (mine) begin
                        f_d.st   = ST_DRIVE;
                        f_d.word = status_id;
                        take     = 1'b1;
                    end else begin
                        f_d.st = ST_PASS;
                    end
                end
            end
            ST_DRIVE: f_d.st = ST_ACK;
            ST_ACK:   if (ds_s == 2'b11) f_d.st = ST_IDLE;
            ST_PASS:  if (iackin_s || as_s) f_d.st = ST_IDLE;
            default:  f_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: ST_IDLE, word: 16'd0};
        else        f_q <= f_d;
    end

    assign data_oe   = (f_q.st == ST_DRIVE) || (f_q.st == ST_ACK);
    assign dtack_n   = (f_q.st != ST_ACK);
    assign iackout_n = (f_q.st != ST_PASS);
    assign data_out  = data_oe ? f_q.word : 16'd0;

    // R4
    data_before_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n) |-> $past(data_oe));

    // R6
    hold_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && ds_s != 2'b11) |=> !dtack_n);

    // R7
    excl_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dtack_n && !iackout_n));
endmodule

// File: rtl/vme_roak_irq.sv
module vme_roak_irq
    import vme_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        periph_int,
    input  logic [7:1]  level_sel,
    input  logic [15:0] status_id,
    input  logic        iack_n,
    input  logic        iackin_n,
    input  logic        as_n,
    input  logic [1:0]  ds_n,
    input  logic [3:1]  addr,
    output logic [7:1]  irq_pull,
    output logic        iackout_n,
    output logic        dtack_n,
    output logic        data_oe,
    output logic [15:0] data_out
);
    localparam int NSYNC = 6;

    logic [NSYNC-1:0] raw, synced;
    logic take, pending;

    assign raw = {periph_int, ds_n, as_n, iackin_n, iack_n};

    vme_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(6'b011111)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(raw), .dout(synced)
    );

    vme_irq_req u_req (
        .clk(clk), .rst_n(rst_n), .int_s(synced[5]), .level_sel(level_sel),
        .take(take), .pending(pending), .irq_pull(irq_pull)
    );

    vme_iack_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .iack_s(synced[0]), .iackin_s(synced[1]),
        .as_s(synced[2]), .ds_s(synced[4:3]), .addr(addr), .pending(pending),
        .level_sel(level_sel), .status_id(status_id), .take(take),
        .dtack_n(dtack_n), .iackout_n(iackout_n), .data_oe(data_oe),
        .data_out(data_out)
    );

    // R5
    release_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (irq_pull == 7'd0));
endmodule

// File: tb/vme_roak_irq_tb.sv
module vme_roak_irq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst_n = 0, periph_int = 0;
    logic [7:1]  level_sel = 7'd0;
    logic [15:0] status_id = 16'd0;
    logic        iack_n = 1, iackin_n = 1, as_n = 1;
    logic [1:0]  ds_n = 2'b11;
    logic [3:1]  addr = 3'd0;
    logic [7:1]  irq_pull;
    logic        iackout_n, dtack_n, data_oe;
    logic [15:0] data_out;

    int total = 0, bad = 0;
    bit done = 0;
    logic [15:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vme_roak_irq u_dut (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: every DTACK falling edge must match the next queued word (R4)
    logic prev_dtack = 1'b1;
    always @(negedge clk) begin
        if (rst_n && prev_dtack && !dtack_n) begin
            if (exp_q.size() == 0) begin
                check(0, "R4 unexpected dtack", 32'(data_out), 32'hFFFFFFFF);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check(data_out == e && data_oe, "R4 status word", 32'(data_out), 32'(e));
            end
        end
        prev_dtack = dtack_n;
    end

    task automatic raise_int();
        periph_int = 0; cycles(5);
        periph_int = 1; cycles(6);
    endtask

    task automatic ack(input logic [2:0] a, input bit respond, input string tag);
        bit seen;
        if (respond) exp_q.push_back(status_id);
        addr = a; iack_n = 0; as_n = 0; ds_n = 2'b00; iackin_n = 0;
        seen = 0;
        for (int i = 0; i < 20 && !seen; i++) begin
            cycles(1);
            if (!dtack_n || !iackout_n) seen = 1;
        end
        if (respond) begin
            check(!dtack_n && iackout_n, {tag, " respond"}, {dtack_n, iackout_n}, 2'b01);
            check(irq_pull == 0, "R5 released on ack", 32'(irq_pull), 0);
            cycles(5);
            check(!dtack_n && data_oe, "R6 held while strobes low", {dtack_n, data_oe}, 2'b01);
        end else begin
            check(!iackout_n && dtack_n, {tag, " pass"}, {dtack_n, iackout_n}, 2'b10);
        end
        ds_n = 2'b11; as_n = 1; iack_n = 1; iackin_n = 1;
        cycles(6);
        check(dtack_n && iackout_n && !data_oe, "R6 R10 released",
              {dtack_n, iackout_n, data_oe}, 3'b110);
    endtask

    initial begin
        cycles(3);
        check(irq_pull == 0 && dtack_n && iackout_n && !data_oe, "R1 reset",
              {irq_pull, dtack_n, iackout_n, data_oe}, {7'd0, 3'b110});
        rst_n = 1; cycles(2);

        level_sel = 7'b0000100; status_id = 16'hA5C3;
        raise_int();
        check(irq_pull == 7'b0000100, "R2 level 3", 32'(irq_pull), 32'h4);
        ack(3'd3, 1, "R4");

        cycles(10);
        check(irq_pull == 0, "R9 held high no re-raise", 32'(irq_pull), 0);
        raise_int();
        check(irq_pull == 7'b0000100, "R9 fresh edge", 32'(irq_pull), 32'h4);

        ack(3'd5, 0, "R7");
        check(irq_pull == 7'b0000100, "R7 request kept", 32'(irq_pull), 32'h4);

        status_id = 16'h1234;
        ack(3'd3, 1, "R4");
        ack(3'd3, 0, "R8");

        level_sel = 7'b1000000; status_id = 16'h7E81;
        raise_int();
        check(irq_pull == 7'b1000000, "R2 level 7", 32'(irq_pull), 32'h40);
        ack(3'd7, 1, "R4");

        level_sel = 7'b0000001; status_id = 16'h0F0F;
        raise_int();
        check(irq_pull == 7'b0000001, "R2 level 1", 32'(irq_pull), 32'h1);
        ack(3'd1, 1, "R4");

        level_sel = 7'b0000000;
        raise_int();
        check(irq_pull == 0, "R3 zero config", 32'(irq_pull), 0);
        level_sel = 7'b0011000;
        raise_int();
        check(irq_pull == 0, "R3 two bits", 32'(irq_pull), 0);
        ack(3'd4, 0, "R3");

        cycles(4);
        check(exp_q.size() == 0, "R4 all words seen", exp_q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule